// File: doc/BRIEF.md
# Switch CPU-Port Tag Inserter

This block sits on the path from a host CPU to the CPU port of an Ethernet switch. Untagged frames without FCS arrive one byte per beat on an AXI4-Stream style interface. A separate egress port number goes with each frame. The block first zero-pads any frame shorter than 60 bytes, which is the 64-byte wire minimum once the FCS is added later. It then splices an 8-byte switch tag in directly after the two MAC address fields, ahead of the original EtherType. The tag tells the switch to forward the frame to exactly one port. Priority forcing, filtering-ID forcing and VLAN-format preservation are never requested, so those tag fields are always zero.

The egress port number is read on the first byte of each frame. If a port number cannot be expressed in the 11-bit forwarding mask, the block swallows that frame and emits nothing. Valid/ready flow control is honoured on both sides. While the tag bytes are being emitted, the input side is stalled.

Top module: `cputag_inserter`

## Requirements
- R1: An input frame of L bytes leaves as max(L, 60) + 8 bytes. Any byte added by padding is 0x00.
- R2: Output bytes 0 to 11 are the first 12 untagged bytes. Output byte 20 onward is untagged byte 12 onward, in order.
- R3: Output bytes 12 to 15 are 0x88, 0x99, 0x04, 0x00. These are the tag EtherType, the protocol number and a zero reason code.
- R4: Output bytes 16 and 17 are 0x00 and 0x20. Only the learning-disable bit (bit 5 of this big-endian word) is set.
- R5: Output bytes 18 and 19 form a big-endian word. Bit 15 (the allowance flag) and bits 14:11 are 0. Bits 10:0 hold a mask whose only set bit is bit P, where P is the egress port number.
- R6: The port number is taken on the first input byte of a frame only. Later changes to port_i within the frame do not affect the tag.
- R7: A frame whose port number is 11 or more is accepted in full on the input and produces no output bytes. The next frame is handled normally.
- R8: m_tlast_o is high on the last output byte of each frame and on no other byte.
- R9: s_tready_o is low whenever one of the 8 tag bytes is on the output.
- R10: While m_tvalid_o is high and m_tready_i is low, m_tvalid_o, m_tdata_o and m_tlast_o hold their values into the next cycle.
- R11: A frame shorter than 12 bytes has its header completed with zero bytes up to byte 11. The tag still starts at output byte 12.
- R12: After reset, m_tvalid_o is low. s_tready_o follows m_tready_i, ready to take the first byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_tdata_i | input | 8 | Untagged frame byte |
| s_tvalid_i | input | 1 | Input byte valid |
| s_tready_o | output | 1 | Input byte accepted |
| s_tlast_i | input | 1 | Last byte of untagged frame |
| port_i | input | 4 | Egress switch port, read on the first byte |
| m_tdata_o | output | 8 | Tagged frame byte |
| m_tvalid_o | output | 1 | Output byte valid |
| m_tready_i | input | 1 | Downstream ready |
| m_tlast_o | output | 1 | Last byte of tagged frame |

## Verification
Several properties are checked on every cycle:
- the input stall during tag emission;
- output stability under backpressure;
- the first tag byte sitting at output offset 12;
- no frame ending before 68 bytes;
- silence on the output when a frame starts with an unreachable port.

Some behaviour can only be shown by the bench's scenarios, which compare whole frames against a model. That covers:
- the exact byte-for-byte placement of data and padding;
- the full contents of the port mask;
- the port being ignored after the first byte;
- recovery after a dropped frame, across lengths around 12 and 60 bytes, with random gaps on both sides.

// File: rtl/cputag_pkg.sv
package cputag_pkg;
  typedef enum logic [1:0] {ST_DATA, ST_TAG, ST_DROP} cputag_st_e;

  localparam int unsigned TAG_BYTES = 8;
  localparam logic [15:0] TAG_ETYPE = 16'h8899;
  localparam logic [7:0]  TAG_PROTO = 8'h04;
  localparam logic [7:0]  TAG_REASON_TX = 8'h00;
  localparam logic [15:0] TAG_CTRL_TX = 16'h0020;  // learning disabled, nothing forced
endpackage

// File: rtl/cputag_port_dec.sv
module cputag_port_dec #(
  parameter int unsigned NUM_PORTS = 11,
  parameter int unsigned PORT_W    = 4
) (
  input  logic [PORT_W-1:0]    port_i,
  output logic [NUM_PORTS-1:0] mask_o,
  output logic                 ok_o
);
  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_bit
    assign mask_o[g] = (port_i == PORT_W'(g));
  end
  assign ok_o = |mask_o;
endmodule

// File: rtl/cputag_tag_gen.sv
module cputag_tag_gen
  import cputag_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 11,
  localparam int unsigned IDX_W    = $clog2(TAG_BYTES),
  localparam int unsigned RSV_W    = 15 - NUM_PORTS
) (
  input  logic [NUM_PORTS-1:0] mask_i,
  input  logic [IDX_W-1:0]     idx_i,
  output logic [7:0]           byte_o
);
  logic [TAG_BYTES*8-1:0] tag_vec;
  logic [7:0] tag_b [TAG_BYTES];

  assign tag_vec = {TAG_ETYPE, TAG_PROTO, TAG_REASON_TX, TAG_CTRL_TX,
                    1'b0, {RSV_W{1'b0}}, mask_i};

  for (genvar g = 0; g < TAG_BYTES; g++) begin : g_byte
    assign tag_b[g] = tag_vec[TAG_BYTES*8-1-8*g -: 8];
  end

  assign byte_o = tag_b[idx_i];
endmodule

// File: rtl/cputag_len_cnt.sv
module cputag_len_cnt #(
  parameter int unsigned LIMIT = 60,
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               cnt_o <= '0;
    else if (clr_i)                            cnt_o <= '0;
    else if (inc_i && cnt_o != CNT_W'(LIMIT))  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/cputag_inserter.sv
module cputag_inserter
  import cputag_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 11,
  parameter int unsigned PORT_W    = 4,
  parameter int unsigned MIN_LEN   = 60,
  parameter int unsigned ADDR_LEN  = 12,
  localparam int unsigned CNT_W    = $clog2(MIN_LEN + 1),
  localparam int unsigned IDX_W    = $clog2(TAG_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        s_tdata_i,
  input  logic              s_tvalid_i,
  output logic              s_tready_o,
  input  logic              s_tlast_i,
  input  logic [PORT_W-1:0] port_i,
  output logic [7:0]        m_tdata_o,
  output logic              m_tvalid_o,
  input  logic              m_tready_i,
  output logic              m_tlast_o
);
  cputag_st_e           st_q;
  logic                 in_done_q;
  logic [IDX_W-1:0]     tidx_q;
  logic [NUM_PORTS-1:0] mask_q, port_mask;
  logic                 port_ok;
  logic [CNT_W-1:0]     cnt;
  logic [7:0]           tag_byte;
  logic                 first_beat, drop_now, at_min, in_fire, out_fire;
  logic                 tag_phase;

  cputag_port_dec #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_dec (
    .port_i(port_i), .mask_o(port_mask), .ok_o(port_ok)
  );

  cputag_tag_gen #(.NUM_PORTS(NUM_PORTS)) u_tag (
    .mask_i(mask_q), .idx_i(tidx_q), .byte_o(tag_byte)
  );

  cputag_len_cnt #(.LIMIT(MIN_LEN), .CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (st_q == ST_DATA && out_fire && m_tlast_o),
    .inc_i (st_q == ST_DATA && out_fire),
    .cnt_o (cnt)
  );

  assign first_beat = (st_q == ST_DATA) && (cnt == '0) && !in_done_q;
  assign drop_now   = first_beat && !port_ok;
  assign at_min     = cnt >= CNT_W'(MIN_LEN - 1);
  assign tag_phase  = (st_q == ST_TAG);
  assign in_fire    = s_tvalid_i && s_tready_o;
  assign out_fire   = m_tvalid_o && m_tready_i;

  always_comb begin
    s_tready_o = 1'b0;
    m_tvalid_o = 1'b0;
    m_tdata_o  = '0;
    m_tlast_o  = 1'b0;
    unique case (st_q)
      ST_DATA: begin
        if (drop_now) begin
          s_tready_o = 1'b1;
        end else if (in_done_q) begin
          m_tvalid_o = 1'b1;      // zero padding
          m_tlast_o  = at_min;
        end else begin
          m_tvalid_o = s_tvalid_i;
          s_tready_o = m_tready_i;
          m_tdata_o  = s_tdata_i;
          m_tlast_o  = s_tlast_i && at_min;
        end
      end
      ST_TAG: begin
        m_tvalid_o = 1'b1;
        m_tdata_o  = tag_byte;
      end
      ST_DROP: s_tready_o = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_DATA;
      in_done_q <= 1'b0;
      tidx_q    <= '0;
      mask_q    <= '0;
    end else begin
      unique case (st_q)
        ST_DATA: begin
          if (drop_now) begin
            if (in_fire && !s_tlast_i) st_q <= ST_DROP;
          end else if (out_fire) begin
            if (first_beat) mask_q <= port_mask;
            if (m_tlast_o) begin
              in_done_q <= 1'b0;
            end else begin
              if (!in_done_q && s_tlast_i) in_done_q <= 1'b1;
              if (cnt == CNT_W'(ADDR_LEN - 1)) begin
                st_q   <= ST_TAG;
                tidx_q <= '0;
              end
            end
          end
        end
        ST_TAG: begin
          if (out_fire) begin
            tidx_q <= tidx_q + 1'b1;
            if (tidx_q == IDX_W'(TAG_BYTES - 1)) st_q <= ST_DATA;
          end
        end
        ST_DROP: begin
          if (in_fire && s_tlast_i) st_q <= ST_DATA;
        end
        default: st_q <= ST_DATA;
      endcase
    end
  end
endmodule

// File: rtl/cputag_chk.sv
module cputag_chk #(
  parameter int unsigned NUM_PORTS = 11,
  parameter int unsigned PORT_W    = 4,
  parameter int unsigned MIN_LEN   = 60,
  parameter int unsigned ADDR_LEN  = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              s_tvalid_i,
  input logic              s_tready_o,
  input logic              s_tlast_i,
  input logic [PORT_W-1:0] port_i,
  input logic [7:0]        m_tdata_o,
  input logic              m_tvalid_o,
  input logic              m_tready_i,
  input logic              m_tlast_o,
  input logic              tag_phase
);
  logic [7:0] obeat;
  logic       in_first;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      obeat    <= '0;
      in_first <= 1'b1;
    end else begin
      if (m_tvalid_o && m_tready_i) begin
        if (m_tlast_o)            obeat <= '0;
        else if (obeat != 8'hff)  obeat <= obeat + 1'b1;
      end
      if (s_tvalid_i && s_tready_o) in_first <= s_tlast_i;
    end
  end

  // R9
  tag_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_phase |-> !s_tready_o);

  // R10
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_tvalid_o && !m_tready_i) |=> (m_tvalid_o && $stable(m_tdata_o) && $stable(m_tlast_o)));

  // R1
  min_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_tvalid_o && m_tlast_o) |-> (obeat >= 8'(MIN_LEN + 7)));

  // R3
  tag_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_tvalid_o && obeat == 8'(ADDR_LEN)) |-> (m_tdata_o == 8'h88));

  // R7
  drop_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_first && s_tvalid_i && obeat == '0 && port_i >= PORT_W'(NUM_PORTS)) |-> !m_tvalid_o);
endmodule

bind cputag_inserter cputag_chk #(
  .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .MIN_LEN(MIN_LEN), .ADDR_LEN(ADDR_LEN)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .s_tvalid_i(s_tvalid_i), .s_tready_o(s_tready_o),
  .s_tlast_i(s_tlast_i), .port_i(port_i), .m_tdata_o(m_tdata_o), .m_tvalid_o(m_tvalid_o),
  .m_tready_i(m_tready_i), .m_tlast_o(m_tlast_o), .tag_phase(tag_phase)
);

// File: tb/cputag_inserter_tb_top.sv
module cputag_inserter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] s_tdata = '0;
  logic       s_tvalid = 1'b0, s_tlast = 1'b0;
  logic       s_tready;
  logic [3:0] port = '0;
  logic [7:0] m_tdata;
  logic       m_tvalid, m_tlast;
  logic       m_tready = 1'b1;

  always #10 clk = ~clk;

  cputag_inserter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .s_tdata_i(s_tdata), .s_tvalid_i(s_tvalid),
    .s_tready_o(s_tready), .s_tlast_i(s_tlast), .port_i(port), .m_tdata_o(m_tdata),
    .m_tvalid_o(m_tvalid), .m_tready_i(m_tready), .m_tlast_o(m_tlast)
  );

  // {len[15:8], port[7:4], 2'b0, backpressure[1], input gaps[0]}
  localparam int NV = 11;
  localparam logic [15:0] VEC [NV] = '{
    {8'd64, 4'd0, 4'b0000}, {8'd60, 4'd10, 4'b0010}, {8'd59, 4'd5, 4'b0001},
    {8'd12, 4'd3, 4'b0011}, {8'd1, 4'd7, 4'b0000}, {8'd11, 4'd1, 4'b0010},
    {8'd13, 4'd2, 4'b0000}, {8'd100, 4'd9, 4'b0011}, {8'd20, 4'd11, 4'b0000},
    {8'd70, 4'd15, 4'b0010}, {8'd61, 4'd4, 4'b0011}
  };

  int checks = 0, failures = 0;
  logic [7:0] obuf [256];
  int obuf_n = 0, last_cnt = 0, last_at = 0, frames_done = 0;
  int stall_err = 0, tagrdy_err = 0;
  logic bp_en = 1'b0;
  logic [15:0] lfsr = 16'hace1;
  logic prev_stall = 1'b0, pl = 1'b0;
  logic [7:0] pd = '0;

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    m_tready <= bp_en ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  always @(negedge clk) begin
    #4;
    if (rst_n) begin
      if (prev_stall && !(m_tvalid && m_tdata == pd && m_tlast == pl)) stall_err++;
      prev_stall = m_tvalid && !m_tready;
      pd = m_tdata;
      pl = m_tlast;
      if (m_tvalid && obuf_n >= 12 && obuf_n < 20 && s_tready) tagrdy_err++;
      if (m_tvalid && m_tready) begin
        if (obuf_n < 256) obuf[obuf_n] = m_tdata;
        obuf_n++;
        if (m_tlast) begin
          last_cnt++;
          last_at = obuf_n;
          frames_done++;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] in_byte(input int v, input int i);
    return 8'((i * 13 + v * 29 + 1) & 255);
  endfunction

  function automatic logic [7:0] exp_byte(input int v, input int len, input int p, input int k);
    logic [10:0] mask;
    mask = 11'(1 << p);
    if (k < 12) return (k < len) ? in_byte(v, k) : 8'h00;
    case (k)
      12: return 8'h88;
      13: return 8'h99;
      14: return 8'h04;
      15: return 8'h00;
      16: return 8'h00;
      17: return 8'h20;
      18: return {5'b0, mask[10:8]};
      19: return mask[7:0];
      default: return ((k - 8) < len) ? in_byte(v, k - 8) : 8'h00;
    endcase
  endfunction

  task automatic send(input int v, input int len, input logic [3:0] p, input bit gap);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (gap && (i % 3 == 1)) begin
        s_tvalid = 1'b0;
        @(negedge clk);
      end
      if (i == 0) port = p;
      else port = p ^ 4'd6;  // R6: port disturbed after the first byte
      s_tvalid = 1'b1;
      s_tdata = in_byte(v, i);
      s_tlast = (i == len - 1);
      #2;
      while (!s_tready) begin
        @(negedge clk);
        #2;
      end
    end
    @(negedge clk);
    s_tvalid = 1'b0;
    s_tlast = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #4;
    check(!m_tvalid, "R12 valid after reset", int'(m_tvalid), 0);
    check(s_tready, "R12 ready after reset", int'(s_tready), 1);

    for (int v = 0; v < NV; v++) begin
      int len, p, exp_len, fd0, m_hdr, m_pad, m_dat, m_r3, m_r4, m_r5;
      bit bp, gap;
      len = int'(VEC[v][15:8]);
      p = int'(VEC[v][7:4]);
      bp = VEC[v][1];
      gap = VEC[v][0];
      obuf_n = 0;
      last_cnt = 0;
      last_at = 0;
      stall_err = 0;
      tagrdy_err = 0;
      bp_en = bp;
      fd0 = frames_done;
      send(v, len, 4'(p), gap);
      if (p >= 11) begin
        repeat (40) @(negedge clk);
        check(obuf_n == 0, "R7 dropped frame emits nothing", obuf_n, 0);
        continue;
      end
      for (int t = 0; t < 600 && frames_done == fd0; t++) @(negedge clk);
      repeat (2) @(negedge clk);
      exp_len = ((len > 60) ? len : 60) + 8;
      check(obuf_n == exp_len, "R1 output length", obuf_n, exp_len);
      m_hdr = 0; m_pad = 0; m_dat = 0; m_r3 = 0; m_r4 = 0; m_r5 = 0;
      for (int k = 0; k < exp_len && k < obuf_n; k++) begin
        if (obuf[k] !== exp_byte(v, len, p, k)) begin
          if (k < 12) m_hdr++;
          else if (k < 16) m_r3++;
          else if (k < 18) m_r4++;
          else if (k < 20) m_r5++;
          else if (k - 8 < len) m_dat++;
          else m_pad++;
        end
      end
      if (len < 12) check(m_hdr == 0, "R11 short header padded", m_hdr, 0);
      else check(m_hdr == 0, "R2 address bytes", m_hdr, 0);
      check(m_r3 == 0, "R3 tag words 0-1", m_r3, 0);
      check(m_r4 == 0, "R4 tag word 2", m_r4, 0);
      check(m_r5 == 0, "R5 R6 tag port mask", m_r5, 0);
      check(m_dat == 0, "R2 payload after tag", m_dat, 0);
      check(m_pad == 0, "R1 zero padding", m_pad, 0);
      check(last_cnt == 1 && last_at == exp_len, "R8 tlast position", last_at, exp_len);
      check(tagrdy_err == 0, "R9 input stalled during tag", tagrdy_err, 0);
      check(stall_err == 0, "R10 output held under backpressure", stall_err, 0);
    end

    // R7 directed: a dropped frame directly followed by a good one
    bp_en = 1'b0;
    obuf_n = 0;
    send(50, 5, 4'd12, 1'b0);
    send(51, 3, 4'd0, 1'b0);
    repeat (100) @(negedge clk);
    check(obuf_n == 68, "R7 recovery after drop", obuf_n, 68);
    check(obuf[19] == 8'h01 && obuf[0] == in_byte(51, 0), "R5 mask after drop",
          int'(obuf[19]), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule